// File: doc/BRIEF.md
# Two-Class Interrupt Controller with Position Encoder

The controller samples a vector of level-sensitive interrupt sources each clock. Each source has an enable bit and a steering bit that places it in either the fast class or the normal class. For each class the block keeps a masked status view. This view contains only sources that are asserting, are enabled, and are steered to that class. The block drives one request line per class toward the processor.

Software reaches every register through a small synchronous bus. The enable and steering words, and one priority word, are read/write. The raw, status and encoded readouts are read-only. For each class, an encoder returns the position of the most urgent pending source. The lowest positions carry programmable urgency levels. Every other position follows a fixed order. A pending source stays visible only for as long as its input is high. Software clears a request at the device that raised it.

With default parameters there are 64 sources, as two 32-bit words per view. The lowest 8 positions are programmable, with 3-bit levels. The bus uses word offsets as follows:

- 0–1: raw sources.
- 2–3: enable.
- 4–5: steering.
- 6: priority.
- 7–8: fast status.
- 9–10: normal status.
- 11: fast encoded readout.
- 12: normal encoded readout.
- 13–15: unmapped.

Top module: `dual_class_intc`

## Requirements
- R1: After reset, the following all read zero: raw, enable, steering, both status views, both encoded readouts, `fiq_o` and `irq_o`. The priority word reads 0xFAC688. In that word the 3-bit field at bits 3p+2:3p holds level p for positions p = 0..7.
- R2: Source n appears in raw word n/32 at bit n%32. The value is the source input sampled at the previous clock edge.
- R3: Status bit n is set only when source n is high and enabled. It appears in the fast view when steering bit n is 1, and in the normal view when steering bit n is 0. No source appears in both views.
- R4: `fiq_o` is the OR of all fast status bits and `irq_o` is the OR of all normal status bits. Each is registered, so a request rises one clock after the status bit appears.
- R5: An encoded readout returns (position+1) in bits 8:2 of the read word, with all other bits zero. When no source of that class is pending, the readout is zero.
- R6: Among positions 0–7, the pending position with the lowest programmed level wins. When levels are equal, the lower position wins.
- R7: Any pending position in 0–7 outranks every position from 8 to 63. Among positions 8–63, the lower number wins.
- R8: The encoded readout reports the winner's position, never its programmed level.
- R9: Each class's encoded readout depends only on that class's status view.
- R10: Writes to the read-only offsets (0, 1, 7–12) and to unmapped offsets have no effect. Unmapped offsets read zero. Priority bits above bit 23 read zero.
- R11: Read data is registered. It shows the addressed register in the cycle after a read strobe, and it holds its value while no read is strobed.
- R12: Sources are not latched. When a source input drops, its status bit and the class request clear without any software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast-class request |
| irq_o | output | 1 | Normal-class request |

## Verification
The bench builds the block with its defaults: 64 sources, 32-bit words, 8 programmable positions and 3-bit levels. With these values the top source, position 63, produces the readout 0x100, which is the only case that sets bit 8 of the encoded field. The seam between the two status words, position 31 against position 32, also falls in reach. So does the boundary between the programmable group and the fixed group, position 7 against position 8. Because the levels are 3 bits wide, the bench can program every level from 0 to 7, including ties, inversions and the level-7 position-0 case.

// File: rtl/intc_pkg.sv
// Package: shared definitions for the two-class interrupt controller.
// Assumes: class index 1 is the fast class, 0 the normal class.
package intc_pkg;
    typedef enum logic {
        CLS_NORM = 1'b0,
        CLS_FAST = 1'b1
    } cls_e;

    localparam int NUM_CLS = 2;
    // Encoded readout sits this many bits above bit 0 of the read word.
    localparam int CODE_SHIFT = 2;
endpackage

// File: rtl/intc_regbank.sv
// Module: intc_regbank
// Holds the software-writable enable, steering and priority registers.
// Assumes: N_SRC is a multiple of DATA_W; the priority word fits in DATA_W.
// Writes take effect at the clock edge where bus_wr_i is high.
module intc_regbank #(
    parameter int N_SRC  = 64,
    parameter int DATA_W = 32,
    parameter int N_PROG = 8,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [N_SRC-1:0]          en_o,
    output logic [N_SRC-1:0]          sel_o,
    output logic [N_PROG*LVL_W-1:0]   prio_o
);
    localparam int N_WORDS   = N_SRC / DATA_W;
    localparam int EN_BASE   = N_WORDS;
    localparam int SEL_BASE  = 2 * N_WORDS;
    localparam int PRIO_OFF  = 3 * N_WORDS;
    localparam int PRIO_W    = N_PROG * LVL_W;

    logic [N_SRC-1:0]  en_q;
    logic [N_SRC-1:0]  sel_q;
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] prio_rst;

    // Reset value of the priority word: level p for position p.
    always_comb begin
        prio_rst = '0;
        for (int p = 0; p < N_PROG; p++) begin
            prio_rst[p*LVL_W +: LVL_W] = LVL_W'(p);
        end
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        // Enable word w: cleared at reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[w*DATA_W +: DATA_W] <= '0;
            end else if (wr_i && addr_i == ADDR_W'(EN_BASE + w)) begin
                en_q[w*DATA_W +: DATA_W] <= wdata_i;
            end
        end

        // Steering word w: cleared at reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[w*DATA_W +: DATA_W] <= '0;
            end else if (wr_i && addr_i == ADDR_W'(SEL_BASE + w)) begin
                sel_q[w*DATA_W +: DATA_W] <= wdata_i;
            end
        end
    end

    // Priority word: per-position levels, reset to the identity order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= prio_rst;
        end else if (wr_i && addr_i == ADDR_W'(PRIO_OFF)) begin
            prio_q <= wdata_i[PRIO_W-1:0];
        end
    end

    assign en_o   = en_q;
    assign sel_o  = sel_q;
    assign prio_o = prio_q;
endmodule

// File: rtl/intc_prio_enc.sv
// Module: intc_prio_enc
// Finds the most urgent set bit of one class's status view and returns
// its position plus one (zero when nothing is set).
// Assumes: positions below N_PROG take their urgency from prio_i, where a
// lower level wins and a tie goes to the lower position; all of them
// outrank higher positions, which use fixed lowest-number-first order.
module intc_prio_enc #(
    parameter int N_SRC  = 64,
    parameter int N_PROG = 8,
    parameter int LVL_W  = 3,
    parameter int POS_W  = $clog2(N_SRC),
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]         st_i,
    input  logic [N_PROG*LVL_W-1:0]  prio_i,
    output logic [CODE_W-1:0]        code_o
);
    logic [LVL_W-1:0] lvl [N_PROG];
    logic             prog_hit;
    logic [LVL_W-1:0] best_lvl;
    logic [POS_W-1:0] best_pos;
    logic             fix_hit;
    logic [POS_W-1:0] fix_pos;

    for (genvar p = 0; p < N_PROG; p++) begin : g_lvl
        assign lvl[p] = prio_i[p*LVL_W +: LVL_W];
    end

    // Programmable group: strict compare keeps the lower position on ties.
    always_comb begin
        prog_hit = 1'b0;
        best_lvl = '0;
        best_pos = '0;
        for (int i = 0; i < N_PROG; i++) begin
            if (st_i[i] && (!prog_hit || lvl[i] < best_lvl)) begin
                prog_hit = 1'b1;
                best_lvl = lvl[i];
                best_pos = POS_W'(i);
            end
        end
    end

    // Fixed group: scan downward so the lowest set position is kept last.
    always_comb begin
        fix_hit = 1'b0;
        fix_pos = '0;
        for (int i = N_SRC - 1; i >= N_PROG; i--) begin
            if (st_i[i]) begin
                fix_hit = 1'b1;
                fix_pos = POS_W'(i);
            end
        end
    end

    // Merge: the programmable group outranks the fixed group.
    always_comb begin
        if (prog_hit) begin
            code_o = CODE_W'(best_pos) + CODE_W'(1);
        end else if (fix_hit) begin
            code_o = CODE_W'(fix_pos) + CODE_W'(1);
        end else begin
            code_o = '0;
        end
    end
endmodule

// File: rtl/intc_readmux.sv
// Module: intc_readmux
// Selects the addressed register and registers it onto the read bus.
// Assumes: read data updates only on a read strobe and holds otherwise;
// unmapped offsets return zero.
module intc_readmux #(
    parameter int N_SRC  = 64,
    parameter int DATA_W = 32,
    parameter int PRIO_W = 24,
    parameter int CODE_W = 7,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [N_SRC-1:0]      raw_i,
    input  logic [N_SRC-1:0]      en_i,
    input  logic [N_SRC-1:0]      sel_i,
    input  logic [PRIO_W-1:0]     prio_i,
    input  logic [N_SRC-1:0]      fast_st_i,
    input  logic [N_SRC-1:0]      norm_st_i,
    input  logic [CODE_W-1:0]     fast_code_i,
    input  logic [CODE_W-1:0]     norm_code_i,
    output logic [DATA_W-1:0]     rdata_o
);
    import intc_pkg::*;

    localparam int N_WORDS   = N_SRC / DATA_W;
    localparam int RAW_BASE  = 0;
    localparam int EN_BASE   = N_WORDS;
    localparam int SEL_BASE  = 2 * N_WORDS;
    localparam int PRIO_OFF  = 3 * N_WORDS;
    localparam int FST_BASE  = 3 * N_WORDS + 1;
    localparam int NST_BASE  = 4 * N_WORDS + 1;
    localparam int FENC_OFF  = 5 * N_WORDS + 1;
    localparam int NENC_OFF  = 5 * N_WORDS + 2;

    logic [DATA_W-1:0] mux_d;
    logic [DATA_W-1:0] rdata_q;

    // Address decode: word views first, then the single-word registers.
    always_comb begin
        mux_d = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (addr_i == ADDR_W'(RAW_BASE + w)) mux_d = raw_i[w*DATA_W +: DATA_W];
            if (addr_i == ADDR_W'(EN_BASE + w))  mux_d = en_i[w*DATA_W +: DATA_W];
            if (addr_i == ADDR_W'(SEL_BASE + w)) mux_d = sel_i[w*DATA_W +: DATA_W];
            if (addr_i == ADDR_W'(FST_BASE + w)) mux_d = fast_st_i[w*DATA_W +: DATA_W];
            if (addr_i == ADDR_W'(NST_BASE + w)) mux_d = norm_st_i[w*DATA_W +: DATA_W];
        end
        if (addr_i == ADDR_W'(PRIO_OFF)) mux_d = DATA_W'(prio_i);
        if (addr_i == ADDR_W'(FENC_OFF)) mux_d = DATA_W'({fast_code_i, {CODE_SHIFT{1'b0}}});
        if (addr_i == ADDR_W'(NENC_OFF)) mux_d = DATA_W'({norm_code_i, {CODE_SHIFT{1'b0}}});
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= mux_d;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/dual_class_intc.sv
// Module: dual_class_intc (top)
// Samples level-sensitive sources, masks them into fast and normal status
// views, encodes the most urgent position of each class and drives one
// registered request line per class.
// Assumes: sources are held high by their devices until serviced; nothing
// is latched internally; N_SRC is a multiple of DATA_W.
module dual_class_intc #(
    parameter int N_SRC  = 64,
    parameter int DATA_W = 32,
    parameter int N_PROG = 8,
    parameter int LVL_W  = $clog2(N_PROG),
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [3:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              fiq_o,
    output logic              irq_o
);
    import intc_pkg::*;

    localparam int PRIO_W = N_PROG * LVL_W;
    localparam int POS_W  = $clog2(N_SRC);
    localparam int CODE_W = $clog2(N_SRC + 1);

    logic [N_SRC-1:0]   raw_q;
    logic [N_SRC-1:0]   en_q;
    logic [N_SRC-1:0]   sel_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [N_SRC-1:0]   cls_st   [NUM_CLS];
    logic [CODE_W-1:0]  cls_code [NUM_CLS];
    logic [NUM_CLS-1:0] req_q;
    logic [N_SRC-1:0]   fast_st;
    logic [N_SRC-1:0]   norm_st;
    logic [CODE_W-1:0]  fast_code;
    logic [CODE_W-1:0]  norm_code;

    // Source sampling: one register stage, cleared at reset, no latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= src_i;
        end
    end

    intc_regbank #(
        .N_SRC (N_SRC),
        .DATA_W(DATA_W),
        .N_PROG(N_PROG),
        .LVL_W (LVL_W),
        .ADDR_W(ADDR_W)
    ) u_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .wdata_i(bus_wdata_i),
        .en_o   (en_q),
        .sel_o  (sel_q),
        .prio_o (prio_q)
    );

    // Class masking: steering bit 1 selects fast, 0 selects normal.
    assign cls_st[CLS_FAST] = raw_q & en_q & sel_q;
    assign cls_st[CLS_NORM] = raw_q & en_q & ~sel_q;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        intc_prio_enc #(
            .N_SRC (N_SRC),
            .N_PROG(N_PROG),
            .LVL_W (LVL_W),
            .POS_W (POS_W),
            .CODE_W(CODE_W)
        ) u_enc (
            .st_i  (cls_st[c]),
            .prio_i(prio_q),
            .code_o(cls_code[c])
        );

        // Class request: registered OR of the class status view.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[c] <= 1'b0;
            end else begin
                req_q[c] <= |cls_st[c];
            end
        end
    end

    assign fast_st   = cls_st[CLS_FAST];
    assign norm_st   = cls_st[CLS_NORM];
    assign fast_code = cls_code[CLS_FAST];
    assign norm_code = cls_code[CLS_NORM];

    intc_readmux #(
        .N_SRC (N_SRC),
        .DATA_W(DATA_W),
        .PRIO_W(PRIO_W),
        .CODE_W(CODE_W),
        .ADDR_W(ADDR_W)
    ) u_readmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd_i),
        .addr_i     (bus_addr_i),
        .raw_i      (raw_q),
        .en_i       (en_q),
        .sel_i      (sel_q),
        .prio_i     (prio_q),
        .fast_st_i  (fast_st),
        .norm_st_i  (norm_st),
        .fast_code_i(fast_code),
        .norm_code_i(norm_code),
        .rdata_o    (bus_rdata_o)
    );

    assign fiq_o = req_q[CLS_FAST];
    assign irq_o = req_q[CLS_NORM];
endmodule

// File: rtl/dual_class_intc_chk.sv
// Module: dual_class_intc_chk
// Property checker bound to dual_class_intc; observes only, drives nothing.
module dual_class_intc_chk #(
    parameter int N_SRC  = 64,
    parameter int N_PROG = 8,
    parameter int CODE_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_i,
    input logic [N_SRC-1:0]  raw_q,
    input logic [N_SRC-1:0]  fast_st,
    input logic [N_SRC-1:0]  norm_st,
    input logic [CODE_W-1:0] fast_code,
    input logic [CODE_W-1:0] norm_code,
    input logic              fiq_o,
    input logic              irq_o,
    input logic              bus_rd_i,
    input logic [DATA_W-1:0] bus_rdata_o
);
    localparam int POS_W = $clog2(N_SRC);

    // R2: raw view is the source input from the previous edge.
    a_r2_raw_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q == $past(src_i));

    // R3: the two class views never share a source.
    a_r3_views_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_st & norm_st) == '0);

    // R4: requests follow their class views one clock later.
    a_r4_fast_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|fast_st) |=> fiq_o);
    a_r4_fast_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fast_st) |=> !fiq_o);
    a_r4_norm_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|norm_st) |=> irq_o);
    a_r4_norm_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|norm_st) |=> !irq_o);

    // R5: a zero code means that class has nothing pending.
    a_r5_fast_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_code == '0) == (fast_st == '0));
    a_r5_norm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_code == '0) == (norm_st == '0));

    // R8: a nonzero code names a position that is actually pending.
    a_r8_fast_names_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fast_code != '0 |-> fast_st[POS_W'(fast_code - 1'b1)]);
    a_r8_norm_names_pending: assert property (@(posedge clk) disable iff (!rst_n)
        norm_code != '0 |-> norm_st[POS_W'(norm_code - 1'b1)]);

    // R7: a pending programmable position keeps the code inside that group.
    a_r7_prog_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        (|fast_st[N_PROG-1:0]) |-> (fast_code != '0 && fast_code <= CODE_W'(N_PROG)));

    // R11: read data holds while no read is strobed.
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd_i)) |-> $stable(bus_rdata_o));
endmodule

bind dual_class_intc dual_class_intc_chk #(
    .N_SRC (N_SRC),
    .N_PROG(N_PROG),
    .CODE_W(CODE_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .raw_q      (raw_q),
    .fast_st    (fast_st),
    .norm_st    (norm_st),
    .fast_code  (fast_code),
    .norm_code  (norm_code),
    .fiq_o      (fiq_o),
    .irq_o      (irq_o),
    .bus_rd_i   (bus_rd_i),
    .bus_rdata_o(bus_rdata_o)
);

// File: tb/dual_class_intc_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module dual_class_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        wr, rd;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        fiq, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state, written from the requirements.
    logic [63:0] m_en, m_sel;

    localparam logic [3:0] A_RAW = 4'd0, A_EN = 4'd2, A_SEL = 4'd4,
                           A_PRIO = 4'd6, A_FST = 4'd7, A_NST = 4'd9,
                           A_FENC = 4'd11, A_NENC = 4'd12;

    always #4 clk = ~clk;

    dual_class_intc u_dual_class_intc (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .bus_wr_i   (wr),
        .bus_rd_i   (rd),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .fiq_o      (fiq),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    // Drive sources, then wait until they are sampled into the raw view.
    task automatic set_src(input logic [63:0] v);
        src = v;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic set_masks(input logic [63:0] en, input logic [63:0] sel);
        m_en = en; m_sel = sel;
        bus_wr(A_EN, en[31:0]);   bus_wr(A_EN + 4'd1, en[63:32]);
        bus_wr(A_SEL, sel[31:0]); bus_wr(A_SEL + 4'd1, sel[63:32]);
    endtask

    function automatic logic [31:0] pack_lvls(input int l0, input int l1, input int l2,
                                              input int l3, input int l4, input int l5,
                                              input int l6, input int l7);
        int lv [8];
        logic [31:0] w;
        lv = '{l0, l1, l2, l3, l4, l5, l6, l7};
        w = '0;
        for (int p = 0; p < 8; p++) w[p*3 +: 3] = 3'(lv[p]);
        return w;
    endfunction

    // Compare both status views and the request lines against the model.
    task automatic chk_views(input string req);
        logic [63:0] f, n;
        f = src & m_en & m_sel;
        n = src & m_en & ~m_sel;
        rd_chk({req, " fast lo"}, A_FST, f[31:0]);
        rd_chk({req, " fast hi"}, A_FST + 4'd1, f[63:32]);
        rd_chk({req, " norm lo"}, A_NST, n[31:0]);
        rd_chk({req, " norm hi"}, A_NST + 4'd1, n[63:32]);
        chk({req, " R4 fiq"}, {31'd0, fiq}, {31'd0, |f});
        chk({req, " R4 irq"}, {31'd0, irq}, {31'd0, |n});
    endtask

    function automatic logic [31:0] code(input int pos);
        return 32'((pos + 1) << 2);
    endfunction

    task automatic t_reset;
        chk("R1 fiq", {31'd0, fiq}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 6; a++) rd_chk("R1 raw/en/sel", 4'(a), 32'd0);
        rd_chk("R1 prio", A_PRIO, 32'h00FA_C688);
        for (int a = 7; a < 13; a++) rd_chk("R1 status/code", 4'(a), 32'd0);
    endtask

    task automatic t_raw;
        set_src(64'h8000_0001_8000_0001);
        rd_chk("R2 raw lo", A_RAW, 32'h8000_0001);
        rd_chk("R2 raw hi", A_RAW + 4'd1, 32'h8000_0001);
        chk_views("R3 disabled");
        set_src(64'h1234_5678_9ABC_DEF0);
        rd_chk("R2 raw lo", A_RAW, 32'h9ABC_DEF0);
        rd_chk("R2 raw hi", A_RAW + 4'd1, 32'h1234_5678);
        set_src('0);
    endtask

    task automatic t_steer;
        set_masks(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_F0F0_F0F0);
        src = 64'h00FF_00FF_0FF0_0FF0;
        @(posedge clk); @(negedge clk);
        chk("R4 latency fiq", {31'd0, fiq}, 32'd0);
        chk("R4 latency irq", {31'd0, irq}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R4 fiq rises", {31'd0, fiq}, 32'd1);
        chk("R4 irq rises", {31'd0, irq}, 32'd1);
        chk_views("R3 steer");
        set_masks(64'h0000_0000_FFFF_0000, 64'h0000_FFFF_F0F0_F0F0);
        chk_views("R3 partial enable");
        set_src('0);
    endtask

    task automatic t_enc_fixed;
        set_masks(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        set_src(64'h8000_0000_0000_0000);
        rd_chk("R5 pos63", A_FENC, 32'h0000_0100);
        rd_chk("R9 norm empty", A_NENC, 32'd0);
        set_src(64'h8000_0101_0000_0000);
        rd_chk("R7 pos32", A_FENC, code(32));
        set_src(64'h8000_0101_8000_0000);
        rd_chk("R7 pos31", A_FENC, code(31));
        set_src(64'h8000_0101_8000_0300);
        rd_chk("R7 pos8", A_FENC, code(8));
        set_src(64'h8000_0101_8000_0380);
        rd_chk("R7 prog beats fixed", A_FENC, code(7));
        set_src('0);
        rd_chk("R5 none", A_FENC, 32'd0);
    endtask

    task automatic t_enc_prog;
        set_masks(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_wr(A_PRIO, pack_lvls(7, 6, 5, 0, 4, 0, 3, 2));
        set_src(64'h0000_0100_0000_0029);
        rd_chk("R6 tie lower pos", A_FENC, code(3));
        set_src(64'h0000_0100_0000_0021);
        rd_chk("R6 level wins", A_FENC, code(5));
        set_src(64'h0000_0100_0000_0001);
        rd_chk("R8 position not level", A_FENC, code(0));
        bus_wr(A_PRIO, pack_lvls(0, 0, 1, 0, 0, 0, 0, 0));
        set_src(64'h0000_0000_0000_0044);
        rd_chk("R6 high pos low level", A_FENC, code(6));
        bus_wr(A_PRIO, pack_lvls(0, 1, 2, 3, 4, 5, 6, 7));
        set_src('0);
    endtask

    task automatic t_class_sep;
        set_masks(64'hFFFF_FFFF_FFFF_FFFF, 64'h0004_0000_0000_0000);
        set_src(64'h0004_0000_0000_0002);
        rd_chk("R9 fast code", A_FENC, code(50));
        rd_chk("R9 norm code", A_NENC, code(1));
        set_src('0);
    endtask

    task automatic t_bus;
        logic [31:0] d;
        set_masks(64'h0000_0000_0000_00FF, '0);
        set_src(64'h0000_0000_0000_0010);
        bus_wr(A_RAW, 32'hFFFF_FFFF);
        bus_wr(A_NST, 32'hFFFF_FFFF);
        bus_wr(A_NENC, 32'hFFFF_FFFF);
        bus_wr(4'd13, 32'hFFFF_FFFF);
        bus_wr(4'd15, 32'hFFFF_FFFF);
        rd_chk("R10 raw unchanged", A_RAW, 32'h0000_0010);
        rd_chk("R10 status unchanged", A_NST, 32'h0000_0010);
        rd_chk("R10 code unchanged", A_NENC, code(4));
        rd_chk("R10 en unchanged", A_EN, 32'h0000_00FF);
        rd_chk("R10 sel unchanged", A_SEL, 32'd0);
        rd_chk("R10 unmapped 13", 4'd13, 32'd0);
        rd_chk("R10 unmapped 15", 4'd15, 32'd0);
        bus_wr(A_PRIO, 32'hFFFF_FFFF);
        rd_chk("R10 prio upper", A_PRIO, 32'h00FF_FFFF);
        bus_wr(A_PRIO, 32'h00FA_C688);
        bus_rd(A_EN, d);
        addr = A_SEL;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 hold", rdata, 32'h0000_00FF);
        set_src('0);
    endtask

    task automatic t_level;
        set_masks(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        set_src(64'h0000_0001_0000_0001);
        @(posedge clk); @(negedge clk);
        chk_views("R12 pending");
        set_src('0);
        @(posedge clk); @(negedge clk);
        chk_views("R12 cleared");
        rd_chk("R12 fast code", A_FENC, 32'd0);
        rd_chk("R12 norm code", A_NENC, 32'd0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        m_en = '0; m_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_steer();
        t_enc_fixed();
        t_enc_prog();
        t_class_sep();
        t_bus();
        t_level();
        done = 1'b1;
        report();
    end
endmodule